// File: doc/BRIEF.md
# Reply Packet Transmitter

This block assembles packets that travel from the unit back to the host. It turns each one into a stream of bytes for a UART transmitter, using a valid/ready handshake. Packets come from two sources. The first is a solicited reply that a command decoder issues: a bare status reply, or a data reply whose payload the decoder has already written into a small buffer. The second is an unsolicited input event, which carries an address byte and a command byte.

Every packet begins with a four-byte header: the unit-to-host sync byte, the reply code, a zero length-high byte, and the payload length. The payload follows the header. Each source has one pending slot. When both slots hold a request, the solicited slot is served first. A packet is always sent complete before the next one starts. The command decoder marks the reply to a bootloader-entry command, and the block drops an acknowledge that carries that mark. Choosing which reply to send, and the UART bit timing, are left to the neighbouring blocks.

Top module: `rpkt_tx`

## Requirements
- R1: The first byte of every packet is 0x55.
- R2: After the sync byte, a packet carries its reply code, then 0x00, then the payload length N, then exactly N payload bytes, and then it ends.
- R3: A solicited reply takes its code from `sol_kind`: 0 gives 0x00 (sync), 1 gives 0x01 (acknowledge), 2 gives 0x02 (negative acknowledge), 3 gives 0xFF (not implemented).
- R4: A solicited reply with length N sends buffer entries 0 to N-1 in ascending address order. N = 0 sends the header only.
- R5: A requested length above 59 is sent as 59, so a packet never exceeds 63 bytes.
- R6: An event packet has code 0x03 and length 2, and its payload is `evt_addr` followed by `evt_cmd`, both sampled with the request.
- R7: A solicited request with `sol_boot` = 1 and `sol_kind` = 1 (acknowledge) produces no packet. Other kinds with `sol_boot` = 1 are sent normally.
- R8: When both a solicited and an event request are pending, the solicited packet goes out first. An event that arrives while a packet is being sent waits until that packet has ended.
- R9: `sol_req` is ignored while a solicited reply is pending or being sent. `evt_req` is ignored while an event is pending or being sent.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R11: `busy` rises in the cycle after a request is accepted. It stays high until the last byte of the last pending packet has been accepted downstream. After reset, `busy` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sol_req | input | 1 | Request a solicited reply (one-cycle pulse) |
| sol_kind | input | 2 | Status kind selecting the reply code |
| sol_len | input | 6 | Payload length of the solicited reply |
| sol_boot | input | 1 | Request answers a bootloader-entry command |
| evt_req | input | 1 | Request an unsolicited event packet (one-cycle pulse) |
| evt_addr | input | 8 | Event address byte |
| evt_cmd | input | 8 | Event command byte |
| buf_we | input | 1 | Payload buffer write enable |
| buf_waddr | input | 6 | Payload buffer write address |
| buf_wdata | input | 8 | Payload buffer write data |
| tx_ready | input | 1 | Downstream accepts the current byte |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_data | output | 8 | Outgoing byte |
| busy | output | 1 | A packet is pending or in progress |

## Verification
The bench sweeps every requested length from 0 to 63 and applies several downstream ready patterns. This would expose an off-by-one on the last payload byte, a length that wraps instead of saturating at 59, and a byte that is lost or repeated when `tx_ready` drops. Solicited and event requests are issued in the same cycle and part-way through a packet, which catches an arbiter that favours the event or splices one packet into another. Duplicate requests are issued while a slot is full, which shows whether a design overwrites or queues them. Bootloader-marked requests of each kind show whether a design suppresses too much or too little. The bench also watches `busy` against the count of accepted bytes, which catches a flag that falls before the final byte.

// File: rtl/rpkt_pkg.sv
package rpkt_pkg;

  localparam logic [7:0] SYNC_U2H = 8'h55;
  localparam logic [7:0] EVT_CODE = 8'h03;
  localparam logic [7:0] EVT_LEN  = 8'd2;
  localparam int         HDR_LEN  = 4;

  typedef enum logic [1:0] {
    RK_SYNC = 2'd0,
    RK_ACK  = 2'd1,
    RK_NACK = 2'd2,
    RK_NIMP = 2'd3
  } rkind_e;

  typedef struct packed {
    logic       is_evt;
    logic [7:0] code;
    logic [7:0] len;
    logic [7:0] eaddr;
    logic [7:0] ecmd;
  } frame_t;

  function automatic logic [7:0] kind_code(rkind_e k);
    logic [7:0] c;
    case (k)
      RK_SYNC: c = 8'h00;
      RK_ACK:  c = 8'h01;
      RK_NACK: c = 8'h02;
      default: c = 8'hFF;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rpkt_rst_sync.sv
module rpkt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/rpkt_buf.sv
module rpkt_buf #(
  parameter int DEPTH = 59,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we && (int'(waddr) == i)) begin
        mem_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (int'(raddr) < DEPTH) begin
      rdata = mem_q[raddr];
    end
  end

endmodule

// File: rtl/rpkt_arb.sv
module rpkt_arb
  import rpkt_pkg::*;
#(
  parameter int MAX_LEN = 59,
  parameter int LEN_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sol_req,
  input  logic [1:0]       sol_kind,
  input  logic [LEN_W-1:0] sol_len,
  input  logic             sol_boot,
  input  logic             evt_req,
  input  logic [7:0]       evt_addr,
  input  logic [7:0]       evt_cmd,
  input  logic             ser_idle,
  input  logic             ser_cur_evt,
  output logic             grant,
  output frame_t           frame,
  output logic             pend_any
);

  localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(MAX_LEN);

  logic             sol_pend_q, sol_pend_d;
  logic             evt_pend_q, evt_pend_d;
  logic [7:0]       sol_code_q;
  logic [LEN_W-1:0] sol_len_q;
  logic [7:0]       evt_addr_q, evt_cmd_q;

  logic             sol_free, evt_free;
  logic             sol_take, evt_take;
  logic             drop_ack;
  logic [LEN_W-1:0] len_eff;

  // Saturation only needed when the length port can exceed the limit
  generate
    if (((1 << LEN_W) - 1) > MAX_LEN) begin : g_clamp
      assign len_eff = (sol_len > LEN_LIM) ? LEN_LIM : sol_len;
    end else begin : g_pass
      assign len_eff = sol_len;
    end
  endgenerate

  always_comb begin
    sol_free = !sol_pend_q && !(!ser_idle && !ser_cur_evt);
    evt_free = !evt_pend_q && !(!ser_idle &&  ser_cur_evt);
    drop_ack = sol_boot && (rkind_e'(sol_kind) == RK_ACK);
    sol_take = sol_req && sol_free && !drop_ack;
    evt_take = evt_req && evt_free;
    grant    = ser_idle && (sol_pend_q || evt_pend_q);
    pend_any = sol_pend_q || evt_pend_q;
  end

  // next-state of the two slots
  always_comb begin
    sol_pend_d = sol_pend_q;
    evt_pend_d = evt_pend_q;
    if (grant && sol_pend_q) begin
      sol_pend_d = 1'b0;
    end
    if (grant && !sol_pend_q) begin
      evt_pend_d = 1'b0;
    end
    if (sol_take) begin
      sol_pend_d = 1'b1;
    end
    if (evt_take) begin
      evt_pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sol_pend_q <= 1'b0;
      evt_pend_q <= 1'b0;
    end else begin
      sol_pend_q <= sol_pend_d;
      evt_pend_q <= evt_pend_d;
    end
  end

  // payload-side registers: enable only, no reset
  always_ff @(posedge clk) begin
    if (sol_take) begin
      sol_code_q <= kind_code(rkind_e'(sol_kind));
      sol_len_q  <= len_eff;
    end
  end

  always_ff @(posedge clk) begin
    if (evt_take) begin
      evt_addr_q <= evt_addr;
      evt_cmd_q  <= evt_cmd;
    end
  end

  always_comb begin
    frame.is_evt = !sol_pend_q;
    frame.code   = sol_pend_q ? sol_code_q : EVT_CODE;
    frame.len    = sol_pend_q ? 8'(sol_len_q) : EVT_LEN;
    frame.eaddr  = evt_addr_q;
    frame.ecmd   = evt_cmd_q;
  end

endmodule

// File: rtl/rpkt_ser.sv
module rpkt_ser
  import rpkt_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  frame_t        frame_in,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          idle,
  output logic          cur_evt,
  output logic [AW-1:0] buf_raddr,
  input  logic [7:0]    buf_rdata
);

  logic       active_q, active_d;
  logic [7:0] idx_q, idx_d;
  frame_t     fr_q;
  logic       step, last;
  logic [7:0] pay_off;

  always_comb begin
    step = active_q && tx_ready;
    last = (idx_q == (fr_q.len + 8'(HDR_LEN - 1)));
  end

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    if (load) begin
      active_d = 1'b1;
      idx_d    = 8'd0;
    end else if (step && last) begin
      active_d = 1'b0;
      idx_d    = 8'd0;
    end else if (step) begin
      idx_d    = idx_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= 8'd0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      fr_q <= frame_in;
    end
  end

  always_comb begin
    pay_off   = idx_q - 8'(HDR_LEN);
    buf_raddr = pay_off[AW-1:0];
  end

  always_comb begin
    case (idx_q)
      8'd0:    tx_data = SYNC_U2H;
      8'd1:    tx_data = fr_q.code;
      8'd2:    tx_data = 8'h00;
      8'd3:    tx_data = fr_q.len;
      default: begin
        if (fr_q.is_evt) begin
          tx_data = (idx_q == 8'(HDR_LEN)) ? fr_q.eaddr : fr_q.ecmd;
        end else begin
          tx_data = buf_rdata;
        end
      end
    endcase
  end

  assign tx_valid = active_q;
  assign idle     = !active_q;
  assign cur_evt  = fr_q.is_evt;

endmodule

// File: rtl/rpkt_tx.sv
module rpkt_tx
  import rpkt_pkg::*;
#(
  parameter  int MAX_LEN = 59,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int AW      = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sol_req,
  input  logic [1:0]       sol_kind,
  input  logic [LEN_W-1:0] sol_len,
  input  logic             sol_boot,
  input  logic             evt_req,
  input  logic [7:0]       evt_addr,
  input  logic [7:0]       evt_cmd,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_waddr,
  input  logic [7:0]       buf_wdata,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             busy
);

  logic          rst_n_i;
  logic          ser_idle, ser_cur_evt;
  logic          grant, pend_any;
  frame_t        frame;
  logic [AW-1:0] buf_raddr;
  logic [7:0]    buf_rdata;

  rpkt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  rpkt_buf #(.DEPTH(MAX_LEN), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (buf_raddr),
    .rdata (buf_rdata)
  );

  rpkt_arb #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .sol_req     (sol_req),
    .sol_kind    (sol_kind),
    .sol_len     (sol_len),
    .sol_boot    (sol_boot),
    .evt_req     (evt_req),
    .evt_addr    (evt_addr),
    .evt_cmd     (evt_cmd),
    .ser_idle    (ser_idle),
    .ser_cur_evt (ser_cur_evt),
    .grant       (grant),
    .frame       (frame),
    .pend_any    (pend_any)
  );

  rpkt_ser #(.AW(AW)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (grant),
    .frame_in  (frame),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .idle      (ser_idle),
    .cur_evt   (ser_cur_evt),
    .buf_raddr (buf_raddr),
    .buf_rdata (buf_rdata)
  );

  assign busy = pend_any || !ser_idle;

endmodule

// File: rtl/rpkt_tx_chk.sv
module rpkt_tx_chk
  import rpkt_pkg::*;
#(
  parameter int MAX_LEN = 59
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       busy
);

  logic [7:0] pos_q;
  logic [7:0] len_q;
  logic       acc, end_now;

  always_comb begin
    acc     = tx_valid && tx_ready;
    end_now = (pos_q == 8'd3) ? (tx_data == 8'd0)
                              : ((pos_q > 8'd3) && (pos_q == len_q + 8'd3));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 8'd0;
      len_q <= 8'd0;
    end else if (acc) begin
      if (pos_q == 8'd3) begin
        len_q <= tx_data;
      end
      pos_q <= end_now ? 8'd0 : pos_q + 8'd1;
    end
  end

  p_sync_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && pos_q == 8'd0) |-> (tx_data == SYNC_U2H));

  p_len_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && pos_q == 8'd2) |-> (tx_data == 8'h00));

  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && pos_q == 8'd1) |->
      (tx_data == 8'h00 || tx_data == 8'h01 || tx_data == 8'h02 ||
       tx_data == 8'h03 || tx_data == 8'hFF));

  p_len_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && pos_q == 8'd3) |-> (tx_data <= 8'(MAX_LEN)));

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_busy_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);

endmodule

bind rpkt_tx rpkt_tx_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .busy     (busy)
);

// File: tb/tb_rpkt_tx.sv
module tb_rpkt_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sol_req = 1'b0;
  logic [1:0] sol_kind = 2'd0;
  logic [5:0] sol_len = 6'd0;
  logic       sol_boot = 1'b0;
  logic       evt_req = 1'b0;
  logic [7:0] evt_addr = 8'd0;
  logic [7:0] evt_cmd = 8'd0;
  logic       buf_we = 1'b0;
  logic [5:0] buf_waddr = 6'd0;
  logic [7:0] buf_wdata = 8'd0;
  logic       tx_ready = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       busy;

  int errors = 0;
  int checks = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] got[$];
  logic [7:0] exp[$];

  always #2 clk = ~clk;

  rpkt_tx dut (
    .clk(clk), .rst_n(rst_n),
    .sol_req(sol_req), .sol_kind(sol_kind), .sol_len(sol_len), .sol_boot(sol_boot),
    .evt_req(evt_req), .evt_addr(evt_addr), .evt_cmd(evt_cmd),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy)
  );

  // ready is set at the falling edge; the byte it accepts is then fixed
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0:       tx_ready = 1'b1;
      1:       tx_ready = lfsr[0] | lfsr[3];
      default: tx_ready = lfsr[0] & lfsr[1];
    endcase
    if (rst_n && tx_valid && tx_ready) got.push_back(tx_data);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 7 + s * 13 + 1) & 255);
  endfunction

  function automatic logic [7:0] code_of(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h02;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic fill_buf(input int n, input int s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      buf_we = 1'b1; buf_waddr = 6'(i); buf_wdata = pat(i, s);
    end
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic send_sol(input int k, input int len, input bit boot);
    @(negedge clk);
    sol_req = 1'b1; sol_kind = 2'(k); sol_len = 6'(len); sol_boot = boot;
    @(negedge clk);
    sol_req = 1'b0; sol_boot = 1'b0;
  endtask

  task automatic send_evt(input logic [7:0] a, input logic [7:0] c);
    @(negedge clk);
    evt_req = 1'b1; evt_addr = a; evt_cmd = c;
    @(negedge clk);
    evt_req = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin
      tick(1);
      n++;
    end
    tick(2);
  endtask

  task automatic exp_sol(input int k, input int len, input int s);
    int n = (len > 59) ? 59 : len;
    exp.push_back(8'h55); exp.push_back(code_of(k));
    exp.push_back(8'h00); exp.push_back(8'(n));
    for (int i = 0; i < n; i++) exp.push_back(pat(i, s));
  endtask

  task automatic exp_evt(input logic [7:0] a, input logic [7:0] c);
    exp.push_back(8'h55); exp.push_back(8'h03);
    exp.push_back(8'h00); exp.push_back(8'h02);
    exp.push_back(a); exp.push_back(c);
  endtask

  task automatic compare(input string tag);
    chk(got.size() == exp.size(), {tag, " byte count"}, got.size(), exp.size());
    for (int i = 0; i < exp.size(); i++) begin
      if (i < got.size())
        chk(got[i] == exp[i], $sformatf("%s byte %0d", tag, i), got[i], exp[i]);
    end
    got.delete();
    exp.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(4);
    // R11: reset state
    chk(busy == 1'b0, "R11 busy in reset", busy, 0);
    chk(tx_valid == 1'b0, "R11 tx_valid in reset", tx_valid, 0);
    rst_n = 1'b1;
    tick(4);
    chk(busy == 1'b0 && tx_valid == 1'b0, "R11 idle after reset", busy, 0);

    // R1 R2 R3: every status kind, header only
    for (int k = 0; k < 4; k++) begin
      send_sol(k, 0, 1'b0);
      wait_idle();
      exp_sol(k, 0, 0);
      compare("R3 status reply");
    end

    // R4 R5 R10: full length sweep under three ready patterns
    for (int len = 0; len < 64; len++) begin
      ready_mode = len % 3;
      fill_buf((len > 59) ? 59 : len, len);
      send_sol(1, len, 1'b0);
      wait_idle();
      exp_sol(1, len, len);
      compare(len > 59 ? "R5 clamp" : "R4 R10 data reply");
    end
    ready_mode = 0;

    // R6: events
    send_evt(8'h00, 8'h0C); wait_idle(); exp_evt(8'h00, 8'h0C); compare("R6 event");
    send_evt(8'hFF, 8'h00); wait_idle(); exp_evt(8'hFF, 8'h00); compare("R6 event");
    ready_mode = 2;
    send_evt(8'hA5, 8'h5A); wait_idle(); exp_evt(8'hA5, 8'h5A); compare("R6 event slow");
    ready_mode = 0;

    // R7: bootloader acknowledge suppressed, others not
    send_sol(1, 0, 1'b1);
    tick(20);
    chk(got.size() == 0, "R7 boot ack bytes", got.size(), 0);
    chk(busy == 1'b0, "R7 boot ack busy", busy, 0);
    fill_buf(5, 7);
    send_sol(1, 5, 1'b1);
    tick(30);
    chk(got.size() == 0, "R7 boot data ack bytes", got.size(), 0);
    send_sol(2, 0, 1'b1);
    wait_idle();
    exp_sol(2, 0, 0);
    compare("R7 boot nack sent");

    // R8: same-cycle requests, solicited first
    fill_buf(3, 99);
    @(negedge clk);
    sol_req = 1'b1; sol_kind = 2'd3; sol_len = 6'd3;
    evt_req = 1'b1; evt_addr = 8'h12; evt_cmd = 8'h34;
    @(negedge clk);
    sol_req = 1'b0; evt_req = 1'b0;
    wait_idle();
    exp_sol(3, 3, 99);
    exp_evt(8'h12, 8'h34);
    compare("R8 same cycle order");

    // R8: event arrives mid-packet and waits
    ready_mode = 2;
    fill_buf(40, 5);
    send_sol(1, 40, 1'b0);
    tick(10);
    send_evt(8'h77, 8'h88);
    wait_idle();
    exp_sol(1, 40, 5);
    exp_evt(8'h77, 8'h88);
    compare("R8 no interleave");

    // R9: duplicate requests while slots are occupied
    fill_buf(10, 3);
    send_sol(1, 10, 1'b0);
    tick(3);
    send_sol(2, 0, 1'b0);
    send_evt(8'h01, 8'h02);
    send_evt(8'h03, 8'h04);
    wait_idle();
    exp_sol(1, 10, 3);
    exp_evt(8'h01, 8'h02);
    compare("R9 ignored requests");

    // R11: busy covers every byte
    fill_buf(8, 11);
    send_sol(0, 8, 1'b0);
    chk(busy == 1'b1, "R11 busy after request", busy, 1);
    begin
      int n = 0;
      while (busy && n < 2000) begin
        tick(1);
        n++;
      end
    end
    chk(got.size() == 12, "R11 bytes done when busy falls", got.size(), 12);
    tick(3);
    chk(busy == 1'b0 && tx_valid == 1'b0, "R11 idle at end", busy, 0);
    exp_sol(0, 8, 11);
    compare("R11 frame");
    ready_mode = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule